// File: doc/BRIEF.md
# Descriptor-Driven Peripheral DMA Sequencer

This block sequences direct memory transfers for ten peripheral channels. Each peripheral owns one request line. It raises that line when its FIFO has gathered enough data or has seen the end of a packet. Software first writes a two-word descriptor for a channel into memory and then arms the channel with a start strobe. From then on the sequencer serves the channel's requests without software involvement.

When a request is served, the sequencer picks one armed, requesting channel and reads that channel's descriptor over a single-beat word bus. It then moves up to a fixed burst of data words and writes the updated descriptor back. In the receive direction data goes from the peripheral FIFO into memory. In the transmit direction data goes from memory into the peripheral FIFO. Once a packet is complete, the channel is disarmed, the done flag is recorded in memory, and an optional sticky per-channel interrupt flag is raised.

Descriptors for channel `c` sit at word addresses `DESC_BASE + 2*c` (buffer address) and `DESC_BASE + 2*c + 1` (control). The control word holds the remaining word count in bits 15:0, the direction in bit 16 (1 = transmit), the interrupt enable in bit 17 and done in bit 18. Memory reads are combinational: `mem_rdata` is valid in the same cycle as `mem_en`. The peripheral side is always ready.

Top module: `pdma_seq`

## Requirements
- R1: A request on a channel that has not been armed by `sw_start` causes no memory access, and that channel's descriptor stays unchanged.
- R2: When several armed channels request in the same cycle, the lowest channel number is served first; its descriptor read (address `DESC_BASE + 2*c`) is the first bus access.
- R3: Each service performs, in this order: a read of the address word, a read of the control word, the data beats, a write of the address word, and a write of the control word.
- R4: In receive (bit 16 = 0), each beat pops one word from the peripheral (`pf_pop`) and writes it to consecutive memory words starting at the descriptor address.
- R5: In transmit (bit 16 = 1), each beat reads consecutive memory words and pushes them to the peripheral (`pf_push`). `pf_eop_out` is high only with the packet's last word.
- R6: In receive, a word popped while `pf_eop_in` is high ends the packet after that word, even if the count is not yet zero; memory past that word is not written.
- R7: A single service moves at most `BURST` (default 4) data words. An unfinished packet is written back with done = 0, and the channel is served again while it stays armed and requesting.
- R8: The written-back descriptor carries the address advanced by the words moved and the count reduced by them. Direction and enable are unchanged, and done (bit 18) is set when the packet ended. Ending a packet disarms the channel.
- R9: `irq[c]` is set when channel `c` ends a packet with enable (bit 17) set, is not set when enable is clear, holds until a `sw_clr[c]` strobe clears it, and a clear strobe has no effect on other channels.
- R10: A descriptor with a zero count moves no data. It is written back at once with done = 1, using exactly four bus accesses.
- R11: After reset no interrupt flag is set, no channel is armed and the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | NCH | Per-channel transfer request |
| sw_start | input | NCH | Per-channel arm strobe |
| sw_clr | input | NCH | Per-channel interrupt clear strobe (write one to clear) |
| irq | output | NCH | Sticky per-channel packet-done flags |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| pf_sel | output | CHW | Channel whose peripheral FIFO is accessed |
| pf_pop | output | 1 | Pop one word from the selected receive FIFO |
| pf_rdata | input | DW | Receive FIFO head word |
| pf_eop_in | input | 1 | Head word is the last of its packet |
| pf_push | output | 1 | Push one word to the selected transmit FIFO |
| pf_wdata | output | DW | Transmit FIFO data |
| pf_eop_out | output | 1 | Pushed word is the last of its packet |

## Verification
A corrupted count, address or burst counter in the sequencer shows up in the written-back descriptor once the service that carried it ends. It also shows up earlier, as misplaced or extra memory writes during the data beats. A wrong channel latch shows up at once as the wrong descriptor address on the first bus access. A lost armed bit either produces bus traffic for an unarmed request or stalls a channel, which shows as a descriptor that never gets its done bit. Errors in the interrupt flags are visible on `irq` in the cycle after the final descriptor write, or in the cycle after a clear strobe.

// File: rtl/pdma_seq_pkg.sv
package pdma_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LDA, S_LDC, S_MOVE, S_WBA, S_WBC
  } seq_st_e;

  localparam int CNT_W    = 16;
  localparam int DIR_POS  = 16;
  localparam int IE_POS   = 17;
  localparam int DONE_POS = 18;
endpackage

// File: rtl/pdma_arb.sv
module pdma_arb #(
  parameter int NCH = 10,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] elig,
  output logic           hit,
  output logic [CHW-1:0] pick
);
  always_comb begin
    hit  = |elig;
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) pick = CHW'(i);
    end
  end
endmodule

// File: rtl/pdma_chst.sv
module pdma_chst #(
  parameter int NCH = 10,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sw_start,
  input  logic [NCH-1:0] sw_clr,
  input  logic           fin_v,
  input  logic           fin_end,
  input  logic           fin_ie,
  input  logic [CHW-1:0] fin_ch,
  output logic [NCH-1:0] armed,
  output logic [NCH-1:0] irq
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_g, arm_d, irq_d, en_g;

    always_comb begin
      hit_g = fin_v && fin_end && (fin_ch == CHW'(g));
      en_g  = hit_g || sw_start[g] || sw_clr[g];
      arm_d = sw_start[g] ? 1'b1 : (hit_g ? 1'b0 : armed[g]);
      irq_d = (hit_g && fin_ie) ? 1'b1 : (sw_clr[g] ? 1'b0 : irq[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed[g] <= 1'b0;
        irq[g]   <= 1'b0;
      end else if (en_g) begin
        armed[g] <= arm_d;
        irq[g]   <= irq_d;
      end
    end
  end
endmodule

// File: rtl/pdma_fsm.sv
module pdma_fsm
  import pdma_seq_pkg::*;
#(
  parameter int          NCH       = 10,
  parameter int          CHW       = $clog2(NCH),
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter int          BURST     = 4,
  parameter logic [15:0] DESC_BASE = 16'h0100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic [CHW-1:0] pick,
  output logic           mem_en,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [CHW-1:0] pf_sel,
  output logic           pf_pop,
  input  logic [DW-1:0]  pf_rdata,
  input  logic           pf_eop_in,
  output logic           pf_push,
  output logic [DW-1:0]  pf_wdata,
  output logic           pf_eop_out,
  output logic           fin_v,
  output logic           fin_end,
  output logic           fin_ie
);
  localparam int BW = $clog2(BURST + 1);

  seq_st_e            st_q, st_d;
  logic [CHW-1:0]     ch_q, ch_d;
  logic [AW-1:0]      addr_q, addr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               dir_q, dir_d, ie_q, ie_d, end_q, end_d;
  logic [BW-1:0]      beat_q, beat_d;
  logic [AW-1:0]      desc_a;
  logic [DW-1:0]      ctl_w;
  logic               stop_pkt, upd;

  assign desc_a  = AW'(DESC_BASE) + AW'({ch_q, 1'b0});
  assign fin_end = end_q;
  assign fin_ie  = ie_q;
  assign pf_sel  = ch_q;
  assign pf_wdata = mem_rdata;

  always_comb begin
    ctl_w = '0;
    ctl_w[CNT_W-1:0] = cnt_q;
    ctl_w[DIR_POS]   = dir_q;
    ctl_w[IE_POS]    = ie_q;
    ctl_w[DONE_POS]  = end_q;
  end

  always_comb begin
    st_d = st_q; ch_d = ch_q; addr_d = addr_q; cnt_d = cnt_q;
    dir_d = dir_q; ie_d = ie_q; end_d = end_q; beat_d = beat_q;
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = desc_a; mem_wdata = '0;
    pf_pop = 1'b0; pf_push = 1'b0; pf_eop_out = 1'b0;
    fin_v = 1'b0; stop_pkt = 1'b0; upd = 1'b1;
    case (st_q)
      S_IDLE: begin
        upd = hit;
        if (hit) begin
          ch_d = pick;
          st_d = S_LDA;
        end
      end
      S_LDA: begin
        mem_en = 1'b1;
        addr_d = mem_rdata[AW-1:0];
        st_d   = S_LDC;
      end
      S_LDC: begin
        mem_en   = 1'b1;
        mem_addr = desc_a + AW'(1);
        cnt_d    = mem_rdata[CNT_W-1:0];
        dir_d    = mem_rdata[DIR_POS];
        ie_d     = mem_rdata[IE_POS];
        beat_d   = '0;
        end_d    = (mem_rdata[CNT_W-1:0] == '0);
        st_d     = end_d ? S_WBA : S_MOVE;
      end
      S_MOVE: begin
        mem_en   = 1'b1;
        mem_addr = addr_q;
        if (dir_q) begin
          pf_push    = 1'b1;
          pf_eop_out = (cnt_q == CNT_W'(1));
          stop_pkt   = pf_eop_out;
        end else begin
          pf_pop    = 1'b1;
          mem_we    = 1'b1;
          mem_wdata = pf_rdata;
          stop_pkt  = (cnt_q == CNT_W'(1)) || pf_eop_in;
        end
        addr_d = addr_q + AW'(1);
        cnt_d  = cnt_q - CNT_W'(1);
        beat_d = beat_q + BW'(1);
        if (stop_pkt || beat_q == BW'(BURST - 1)) begin
          end_d = stop_pkt;
          st_d  = S_WBA;
        end
      end
      S_WBA: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = DW'(addr_q);
        st_d      = S_WBC;
      end
      S_WBC: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_a + AW'(1);
        mem_wdata = ctl_w;
        fin_v     = 1'b1;
        st_d      = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ch_q <= '0; addr_q <= '0; cnt_q <= '0;
      dir_q <= 1'b0; ie_q <= 1'b0; end_q <= 1'b0; beat_q <= '0;
    end else if (upd) begin
      st_q <= st_d; ch_q <= ch_d; addr_q <= addr_d; cnt_q <= cnt_d;
      dir_q <= dir_d; ie_q <= ie_d; end_q <= end_d; beat_q <= beat_d;
    end
  end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq #(
  parameter int          NCH       = 10,
  parameter int          CHW       = $clog2(NCH),
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter int          BURST     = 4,
  parameter logic [15:0] DESC_BASE = 16'h0100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] sw_start,
  input  logic [NCH-1:0] sw_clr,
  output logic [NCH-1:0] irq,
  output logic           mem_en,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [CHW-1:0] pf_sel,
  output logic           pf_pop,
  input  logic [DW-1:0]  pf_rdata,
  input  logic           pf_eop_in,
  output logic           pf_push,
  output logic [DW-1:0]  pf_wdata,
  output logic           pf_eop_out
);
  logic [1:0]     rst_q;
  logic           rst_s_n;
  logic [NCH-1:0] armed;
  logic           hit, fin_v, fin_end, fin_ie;
  logic [CHW-1:0] pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  pdma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .elig(chan_req & armed), .hit(hit), .pick(pick)
  );

  pdma_chst #(.NCH(NCH), .CHW(CHW)) u_chst (
    .clk(clk), .rst_n(rst_s_n), .sw_start(sw_start), .sw_clr(sw_clr),
    .fin_v(fin_v), .fin_end(fin_end), .fin_ie(fin_ie), .fin_ch(pf_sel),
    .armed(armed), .irq(irq)
  );

  pdma_fsm #(.NCH(NCH), .CHW(CHW), .AW(AW), .DW(DW), .BURST(BURST),
             .DESC_BASE(DESC_BASE)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .hit(hit), .pick(pick),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pf_sel(pf_sel), .pf_pop(pf_pop), .pf_rdata(pf_rdata),
    .pf_eop_in(pf_eop_in), .pf_push(pf_push), .pf_wdata(pf_wdata),
    .pf_eop_out(pf_eop_out), .fin_v(fin_v), .fin_end(fin_end), .fin_ie(fin_ie)
  );
endmodule

// File: rtl/pdma_seq_chk.sv
module pdma_seq_chk #(
  parameter int NCH   = 10,
  parameter int CHW   = $clog2(NCH),
  parameter int BURST = 4
) (
  input logic           clk,
  input logic           rst_s_n,
  input logic           pf_pop,
  input logic           pf_push,
  input logic           pf_eop_out,
  input logic [CHW-1:0] pf_sel,
  input logic [NCH-1:0] armed,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] sw_clr
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)               run_q <= '0;
    else if (pf_pop || pf_push) run_q <= run_q + 8'd1;
    else                        run_q <= '0;
  end

  // R1
  armed_move_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pf_pop || pf_push) |-> armed[pf_sel]);

  // R7
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pf_pop || pf_push) |-> (run_q < 8'(BURST)));

  // R5
  eop_push_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    pf_eop_out |-> pf_push);

  // R4
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(pf_pop && pf_push));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|irq) |=> ((~irq & $past(irq) & ~$past(sw_clr)) == '0));
endmodule

bind pdma_seq pdma_seq_chk #(.NCH(NCH), .CHW(CHW), .BURST(BURST)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .pf_pop(pf_pop), .pf_push(pf_push),
  .pf_eop_out(pf_eop_out), .pf_sel(pf_sel), .armed(armed), .irq(irq),
  .sw_clr(sw_clr)
);

// File: tb/pdma_seq_test.sv
module pdma_seq_test;
  localparam int CLK_P = 10;
  localparam int NCH = 10, CHW = 4, AW = 16, DW = 32, BURST = 4;
  localparam logic [15:0] DB = 16'h0100;

  typedef struct packed {
    logic [3:0] ch; logic dir; logic [7:0] cnt; logic ie; logic [7:0] eop;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{4'd3, 1'b0, 8'd10, 1'b1, 8'd0},
    '{4'd9, 1'b1, 8'd5,  1'b1, 8'd0},
    '{4'd0, 1'b0, 8'd10, 1'b0, 8'd3},
    '{4'd5, 1'b1, 8'd4,  1'b0, 8'd0},
    '{4'd7, 1'b0, 8'd1,  1'b1, 8'd1},
    '{4'd6, 1'b0, 8'd9,  1'b1, 8'd6}
  };

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] chan_req = '0, sw_start = '0, sw_clr = '0, irq;
  logic mem_en, mem_we, pf_pop, pf_push, pf_eop_out, pf_eop_in;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, pf_rdata, pf_wdata;
  logic [CHW-1:0] pf_sel;

  logic [31:0] mem [512];
  logic hw_en = 0; logic [8:0] hw_a = '0; logic [31:0] hw_d = '0;
  logic run_clr = 0;
  logic [7:0] cur_v = '0, eop_at = '0;
  logic [15:0] watch_a = '0;
  int rx_idx, tx_n, acc_n, dread_n, run_cur, run_max, first_a;
  logic first_seen;
  logic [31:0] tx_buf [16];
  logic        tx_eop [16];
  int nchk = 0, nerr = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  pdma_seq #(.NCH(NCH), .AW(AW), .DW(DW), .BURST(BURST), .DESC_BASE(DB)) uut (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .sw_start(sw_start),
    .sw_clr(sw_clr), .irq(irq), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pf_sel(pf_sel), .pf_pop(pf_pop), .pf_rdata(pf_rdata),
    .pf_eop_in(pf_eop_in), .pf_push(pf_push), .pf_wdata(pf_wdata),
    .pf_eop_out(pf_eop_out)
  );

  assign mem_rdata = mem[mem_addr[8:0]];
  assign pf_rdata  = 32'hD000_0000 | (32'(cur_v) << 8) | 32'(rx_idx);
  assign pf_eop_in = (eop_at != 0) && (rx_idx == int'(eop_at) - 1);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (hw_en) mem[hw_a] <= hw_d;
    if (mem_en && mem_we) mem[mem_addr[8:0]] <= mem_wdata;
    if (run_clr) begin
      rx_idx <= 0; tx_n <= 0; acc_n <= 0; dread_n <= 0;
      run_cur <= 0; run_max <= 0; first_seen <= 0; first_a <= 0;
    end else begin
      if (pf_pop) rx_idx <= rx_idx + 1;
      if (pf_push && tx_n < 16) begin
        tx_buf[tx_n] <= pf_wdata; tx_eop[tx_n] <= pf_eop_out; tx_n <= tx_n + 1;
      end
      if (mem_en) acc_n <= acc_n + 1;
      if (mem_en && !mem_we && mem_addr == watch_a) dread_n <= dread_n + 1;
      if (mem_en && !first_seen) begin first_seen <= 1; first_a <= int'(mem_addr); end
      if (pf_pop || pf_push) begin
        run_cur <= run_cur + 1;
        if (run_cur + 1 > run_max) run_max <= run_cur + 1;
      end else run_cur <= 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic host_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); hw_en = 1; hw_a = a[8:0]; hw_d = d;
    @(negedge clk); hw_en = 0;
  endtask

  task automatic clr_mon(input logic [15:0] wa);
    @(negedge clk); run_clr = 1; watch_a = wa;
    @(negedge clk); run_clr = 0;
  endtask

  task automatic pulse_start(input int c);
    @(negedge clk); sw_start[c] = 1;
    @(negedge clk); sw_start[c] = 0;
  endtask

  task automatic wait_done(input logic [15:0] ca, output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (mem[ca[8:0]][18] === 1'b1) begin ok = 1; break; end
    end
  endtask

  task automatic run_vec(input int v);
    vec_t t = VEC[v];
    logic [15:0] da = DB + 16'(2 * int'(t.ch));
    logic [15:0] base = 16'h0040 + 16'(v * 16);
    int moved = (!t.dir && t.eop != 0 && t.eop <= t.cnt) ? int'(t.eop) : int'(t.cnt);
    int passes = (moved == 0) ? 1 : (moved + BURST - 1) / BURST;
    int bad = 0;
    bit ok;
    for (int i = 0; i <= int'(t.cnt); i++)
      host_wr(base + 16'(i), t.dir ? (32'hB000_0000 | (32'(v) << 8) | 32'(i)) : 32'hDEAD_BEEF);
    host_wr(da, 32'(base));
    host_wr(da + 1, 32'(t.cnt) | (32'(t.dir) << 16) | (32'(t.ie) << 17));
    cur_v = 8'(v); eop_at = t.eop;
    clr_mon(da);
    pulse_start(int'(t.ch));
    @(negedge clk); chan_req[t.ch] = 1;
    wait_done(da + 1, ok);
    chan_req[t.ch] = 0;
    chk(ok, "R8 done bit set", 32'(ok), 1);
    // R8 written-back control and address
    chk(mem[(da + 1) & 16'h1FF] == (32'(int'(t.cnt) - moved) | (32'(t.dir) << 16) | (32'(t.ie) << 17) | (32'h1 << 18)),
        "R8 control word", mem[(da + 1) & 16'h1FF],
        32'(int'(t.cnt) - moved) | (32'(t.dir) << 16) | (32'(t.ie) << 17) | (32'h1 << 18));
    chk(mem[da[8:0]] == 32'(base) + 32'(moved), "R8 address word", mem[da[8:0]], 32'(base) + 32'(moved));
    // R7 services per packet
    chk(dread_n == passes, "R7 service count", 32'(dread_n), 32'(passes));
    chk(run_max <= BURST, "R7 burst length", 32'(run_max), BURST);
    if (!t.dir) begin
      for (int i = 0; i < moved; i++)
        if (mem[(base + 16'(i)) & 16'h1FF] != (32'hD000_0000 | (32'(v) << 8) | 32'(i))) bad++;
      chk(bad == 0, "R4 receive data", 32'(bad), 0);
      chk(mem[(base + 16'(moved)) & 16'h1FF] == 32'hDEAD_BEEF, "R6 no write past end",
          mem[(base + 16'(moved)) & 16'h1FF], 32'hDEAD_BEEF);
    end else begin
      chk(tx_n == moved, "R5 push count", 32'(tx_n), 32'(moved));
      for (int i = 0; i < moved; i++) begin
        if (tx_buf[i] != (32'hB000_0000 | (32'(v) << 8) | 32'(i))) bad++;
        if (tx_eop[i] != (i == moved - 1)) bad++;
      end
      chk(bad == 0, "R5 transmit data and eop", 32'(bad), 0);
    end
    @(negedge clk);
    chk(irq[t.ch] == t.ie, "R9 irq after packet", 32'(irq[t.ch]), 32'(t.ie));
    if (t.ie) begin
      @(negedge clk); sw_clr[t.ch] = 1;
      @(negedge clk); sw_clr[t.ch] = 0;
      chk(irq[t.ch] == 1'b0, "R9 irq cleared", 32'(irq[t.ch]), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    bit ok;
    run_clr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run_clr = 0;
    // R11 reset state
    chk(irq == '0, "R11 irq after reset", 32'(irq), 0);
    chk(mem_en == 1'b0, "R11 bus idle after reset", 32'(mem_en), 0);

    // R1 unarmed request ignored
    host_wr(DB + 4, 32'h0000_0030);
    host_wr(DB + 5, 32'h0000_0003);
    clr_mon(DB + 4);
    @(negedge clk); chan_req[2] = 1;
    repeat (40) @(negedge clk);
    chk(acc_n == 0, "R1 no bus access when unarmed", 32'(acc_n), 0);
    chk(mem[DB[8:0] + 5] == 32'h3, "R1 descriptor untouched", mem[DB[8:0] + 5], 32'h3);
    chan_req[2] = 0;

    for (int v = 0; v < NV; v++) run_vec(v);

    // R2 priority: channels 4 and 1 together
    host_wr(DB + 8, 32'h0000_00A0); host_wr(DB + 9, 32'h0000_0002);
    host_wr(DB + 2, 32'h0000_00B0); host_wr(DB + 3, 32'h0000_0002);
    cur_v = 8'hEE; eop_at = 0;
    clr_mon(DB + 2);
    pulse_start(4); pulse_start(1);
    @(negedge clk); chan_req[4] = 1; chan_req[1] = 1;
    wait_done(DB + 3, ok);
    chk(first_a == int'(DB) + 2, "R2 lowest channel first", 32'(first_a), 32'(DB) + 2);
    wait_done(DB + 9, ok);
    chk(ok, "R2 second channel served", 32'(ok), 1);
    chan_req = '0;
    // R3 sequence: 2 reads + 2 data + 2 writes per channel
    chk(acc_n == 12, "R3 access count", 32'(acc_n), 12);

    // R10 zero count
    host_wr(DB + 16, 32'h0000_00C0); host_wr(DB + 17, 32'h0002_0000);
    clr_mon(DB + 16);
    pulse_start(8);
    @(negedge clk); chan_req[8] = 1;
    wait_done(DB + 17, ok);
    chan_req[8] = 0;
    @(negedge clk);
    chk(mem[DB[8:0] + 17] == 32'h0006_0000, "R10 control written", mem[DB[8:0] + 17], 32'h0006_0000);
    chk(acc_n == 4, "R10 four accesses", 32'(acc_n), 4);
    chk(rx_idx == 0 && tx_n == 0, "R10 no data moved", 32'(rx_idx + tx_n), 0);
    chk(irq[8] == 1'b1, "R9 irq on zero count", 32'(irq[8]), 1);
    @(negedge clk); sw_clr[3] = 1;
    @(negedge clk); sw_clr[3] = 0;
    chk(irq[8] == 1'b1, "R9 clear of other channel", 32'(irq[8]), 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule